// File: doc/BRIEF.md
# Prescaled Interval Tick Timer

A tick timer for one processor core, controlled through a small window of 32-bit registers. A prescale stage divides the input clock into ticks. A down-counter then counts those ticks and flags expiry after a programmed number of them. Expiry sets a sticky status flag, and that flag can be routed to a single interrupt line. In interval mode the down-counter reloads from its buffered count when it expires, so the interrupt recurs without software help. Without interval mode it expires once and waits. Software then stops it by clearing the start bits.

Every write that software has to confirm leaves a sticky acknowledge bit in a write-status register, and software clears that bit by writing 1 to it. The register bus is a plain single-cycle interface: a write is taken on any clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. There is no back-pressure, and no stream interface exists on this block.

Top module: `tick_timer`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: With control bit 0 (tick run, control at offset 0x20) set and the prescale register (offset 0x00) holding N, one tick occurs every N+1 clocks. Writing the prescale register restarts the prescale phase at zero, and that write cycle produces no tick.
- R3: A write to offset 0x08 always updates the buffered count from bits 30:0. When bit 31 of that write is also 1, the active count is loaded with the same value. Reads of 0x08 return the buffered count.
- R4: While control bit 1 (count run) is set, the active count drops by one on each tick. A tick that finds the count at 1 is an expiry, and an expiry sets status bit 0 (offset 0x30). A count of 0 does not change on ticks.
- R5: With control bit 2 (interval) set, an expiry reloads the active count from the buffered count, so expiries repeat every buffered-count ticks.
- R6: With control bit 2 clear, an expiry leaves the active count at 0, and no further expiry happens until the count is loaded again.
- R7: While control bit 0 is clear the prescale phase holds. While control bit 1 is clear the active count holds.
- R8: Writing 1 to status bit 0 clears it. If an expiry falls in the same cycle as that clear, the flag stays set.
- R9: `irq` is high exactly when status bit 0 and enable bit 0 (offset 0x34) are both 1.
- R10: Write status (offset 0x40) sets bit 0 after a prescale write, bit 1 after a count-buffer write and bit 3 after a control write. Each bit stays set until a 1 is written to it at 0x40.
- R11: Reads return the stored value at each mapped offset, and 0 at any unmapped offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, taken on the clock edge |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Interrupt, status AND enable |

## Verification
An expiry and a software write-1-to-clear of the status flag can land on the same clock edge. To provoke this, the bench sets the prescale to 0 and the interval count to 2, then holds a status-clear write on the bus for twenty consecutive cycles, so some clears meet an expiry. A cycle-accurate reference model in the bench decides the outcome with set-wins priority. The bench compares `irq` with the model on every cycle and reads the status register back afterwards.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_PSC  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CBUF = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_WST  = 8'h40;

  localparam int LOAD_BIT  = 31;
  localparam int WST_PSC   = 0;
  localparam int WST_CBUF  = 1;
  localparam int WST_CTRL  = 3;

  typedef struct packed {
    logic interval;
    logic cnt_run;
    logic tick_run;
  } ctrl_t;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int PSC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PSC_W-1:0] limit,
  output logic             tick
);
  logic [PSC_W-1:0] phase;
  logic             wrap;

  assign wrap = (phase == limit);
  assign tick = run && wrap && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n)        phase <= '0;
    else if (restart)  phase <= '0;
    else if (run)      phase <= wrap ? '0 : phase + 1'b1;
  end
endmodule

// File: rtl/tick_downcounter.sv
module tick_downcounter #(
  parameter int CNT_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             interval,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic             expire,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic step;

  assign step   = run && tick && (count != '0) && !load;
  assign expire = step && (count == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (load)    count <= load_val;
    else if (expire)  count <= interval ? reload_val : '0;
    else if (step)    count <= count - 1'b1;
  end
endmodule

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
  import tick_timer_pkg::*;
#(
  parameter int PSC_W = 32,
  parameter int CNT_W = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              expire,
  output logic [PSC_W-1:0]  psc_q,
  output logic [CNT_W-1:0]  cbuf_q,
  output ctrl_t             ctrl_q,
  output logic              stat_q,
  output logic              ien_q,
  output logic [3:0]        wst_q,
  output logic              psc_wr,
  output logic              cnt_load
);
  logic cbuf_wr, ctrl_wr, stat_wr, ien_wr, wst_wr;

  assign psc_wr   = bus_wr && (bus_addr == OFS_PSC);
  assign cbuf_wr  = bus_wr && (bus_addr == OFS_CBUF);
  assign ctrl_wr  = bus_wr && (bus_addr == OFS_CTRL);
  assign stat_wr  = bus_wr && (bus_addr == OFS_STAT);
  assign ien_wr   = bus_wr && (bus_addr == OFS_IEN);
  assign wst_wr   = bus_wr && (bus_addr == OFS_WST);
  assign cnt_load = cbuf_wr && bus_wdata[LOAD_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psc_q  <= '0;
      cbuf_q <= '0;
      ctrl_q <= '0;
      ien_q  <= 1'b0;
    end else begin
      if (psc_wr)  psc_q  <= bus_wdata[PSC_W-1:0];
      if (cbuf_wr) cbuf_q <= bus_wdata[CNT_W-1:0];
      if (ctrl_wr) ctrl_q <= ctrl_t'(bus_wdata[2:0]);
      if (ien_wr)  ien_q  <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       stat_q <= 1'b0;
    else if (expire)                  stat_q <= 1'b1;
    else if (stat_wr && bus_wdata[0]) stat_q <= 1'b0;
  end

  logic [3:0] wst_set;
  always_comb begin
    wst_set           = '0;
    wst_set[WST_PSC]  = psc_wr;
    wst_set[WST_CBUF] = cbuf_wr;
    wst_set[WST_CTRL] = ctrl_wr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      wst_q <= '0;
    else if (wst_wr) wst_q <= wst_q & ~bus_wdata[3:0];
    else             wst_q <= wst_q | wst_set;
  end

  always_comb begin
    unique case (bus_addr)
      OFS_PSC:  bus_rdata = BUS_W'(psc_q);
      OFS_CBUF: bus_rdata = BUS_W'(cbuf_q);
      OFS_CTRL: bus_rdata = BUS_W'(ctrl_q);
      OFS_STAT: bus_rdata = BUS_W'(stat_q);
      OFS_IEN:  bus_rdata = BUS_W'(ien_q);
      OFS_WST:  bus_rdata = BUS_W'(wst_q);
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int PSC_W = 32,
  parameter int CNT_W = 31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] cbuf_q;
  logic [CNT_W-1:0] count;
  ctrl_t            ctrl_q;
  logic             stat_q, ien_q, psc_wr, cnt_load, tick, expire;
  logic [3:0]       wst_q;

  tick_timer_regs #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .expire(expire),
    .psc_q(psc_q), .cbuf_q(cbuf_q), .ctrl_q(ctrl_q), .stat_q(stat_q),
    .ien_q(ien_q), .wst_q(wst_q), .psc_wr(psc_wr), .cnt_load(cnt_load)
  );

  tick_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.tick_run), .restart(psc_wr),
    .limit(psc_q), .tick(tick)
  );

  tick_downcounter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.cnt_run), .tick(tick),
    .interval(ctrl_q.interval), .load(cnt_load),
    .load_val(bus_wdata[CNT_W-1:0]), .reload_val(cbuf_q),
    .expire(expire), .count(count)
  );

  assign irq = stat_q & ien_q;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int PSC_W = 32,
  parameter int CNT_W = 31
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [7:0]       bus_addr,
  input logic             load_bit,
  input logic             tick,
  input logic             expire,
  input logic             stat_q,
  input logic             cnt_run,
  input logic             interval,
  input logic [PSC_W-1:0] psc_q,
  input logic [CNT_W-1:0] count,
  input logic [3:0]       wst_q
);
  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && psc_q != '0 && !(bus_wr && bus_addr == 8'h00)) |=> !tick);

  // R4
  expire_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (tick && cnt_run));

  // R4
  expire_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> stat_q);

  // R6
  oneshot_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !interval) |=> (count == '0));

  // R7
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_run && !(bus_wr && bus_addr == 8'h08 && load_bit)) |=> $stable(count));

  // R10
  ctrl_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h20) |=> wst_q[3]);
endmodule

bind tick_timer tick_timer_chk #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .load_bit(bus_wdata[31]), .tick(tick), .expire(expire), .stat_q(stat_q),
  .cnt_run(ctrl_q.cnt_run), .interval(ctrl_q.interval), .psc_q(psc_q),
  .count(count), .wst_q(wst_q)
);

// File: tb/tick_timer_test.sv
module tick_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  tick_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // behavioural reference model
  logic [31:0] m_psc = 0, m_phase = 0, m_buf = 0, m_cnt = 0;
  logic [2:0]  m_ctrl = 0;
  logic        m_stat = 0, m_ien = 0;
  logic [3:0]  m_wst = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_psc = 0; m_phase = 0; m_buf = 0; m_cnt = 0;
      m_ctrl = 0; m_stat = 0; m_ien = 0; m_wst = 0;
    end else begin
      bit w0, wl, t, e;
      w0 = bus_wr && bus_addr == 8'h00;
      wl = bus_wr && bus_addr == 8'h08 && bus_wdata[31];
      t  = m_ctrl[0] && (m_phase == m_psc) && !w0;
      e  = m_ctrl[1] && t && (m_cnt == 1) && !wl;
      if (w0) m_phase = 0;
      else if (m_ctrl[0]) m_phase = (m_phase == m_psc) ? 0 : m_phase + 1;
      if (wl) m_cnt = {1'b0, bus_wdata[30:0]};
      else if (e) m_cnt = m_ctrl[2] ? m_buf : 0;
      else if (m_ctrl[1] && t && m_cnt != 0) m_cnt = m_cnt - 1;
      if (e) m_stat = 1;
      else if (bus_wr && bus_addr == 8'h30 && bus_wdata[0]) m_stat = 0;
      if (bus_wr) begin
        case (bus_addr)
          8'h00: begin m_psc = bus_wdata; m_wst[0] = 1; end
          8'h08: begin m_buf = {1'b0, bus_wdata[30:0]}; m_wst[1] = 1; end
          8'h20: begin m_ctrl = bus_wdata[2:0]; m_wst[3] = 1; end
          8'h34: m_ien = bus_wdata[0];
          8'h40: m_wst = m_wst & ~bus_wdata[3:0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return m_psc;
      8'h08: return m_buf;
      8'h20: return {29'd0, m_ctrl};
      8'h30: return {31'd0, m_stat};
      8'h34: return {31'd0, m_ien};
      8'h40: return {28'd0, m_wst};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R9: irq against model on every cycle
  always @(negedge clk) begin
    if (rst_n && !done) check(irq === (m_stat & m_ien), "R9 irq", {31'd0, irq}, {31'd0, m_stat & m_ien});
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(bus_rdata === m_read(a), tag, bus_rdata, m_read(a));
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1;
    // R1 reset state, R11 readback
    rd(8'h00, "R1 psc"); rd(8'h08, "R1 cbuf"); rd(8'h20, "R1 ctrl");
    rd(8'h30, "R1 stat"); rd(8'h34, "R1 ien"); rd(8'h40, "R1 wst");
    check(irq === 1'b0, "R1 irq", {31'd0, irq}, 32'd0);
    rd(8'h10, "R11 unmapped");

    // R10 write acknowledge
    wr(8'h00, 32'd2);
    rd(8'h40, "R10 wst psc");
    rd(8'h00, "R11 psc");
    wr(8'h40, 32'h1);
    rd(8'h40, "R10 wst clear");

    // R3 buffer-only write, then load
    wr(8'h08, 32'd5);
    rd(8'h08, "R3 cbuf");
    rd(8'h40, "R10 wst cbuf");
    wr(8'h08, 32'h8000_0003);
    rd(8'h08, "R3 cbuf load");

    // R2 R4 R6 one-shot
    wr(8'h34, 32'd1);
    wr(8'h20, 32'd3);
    rd(8'h40, "R10 wst ctrl");
    wait_cyc(30);
    rd(8'h30, "R4 expiry");
    check(bus_rdata[0] === 1'b1, "R4 stat set", bus_rdata, 32'd1);
    wr(8'h30, 32'd1);
    rd(8'h30, "R8 clear");
    wait_cyc(40);
    rd(8'h30, "R6 no refire");
    check(bus_rdata[0] === 1'b0, "R6 stays clear", bus_rdata, 32'd0);

    // R5 interval
    wr(8'h08, 32'h8000_0002);
    wr(8'h20, 32'd7);
    for (int i = 0; i < 4; i++) begin
      wait_cyc(12);
      rd(8'h30, "R5 periodic");
      wr(8'h30, 32'd1);
    end

    // R7 halt both stages
    wr(8'h20, 32'd4);
    wr(8'h30, 32'd1);
    wait_cyc(30);
    rd(8'h30, "R7 halted");
    wr(8'h20, 32'd5);
    wait_cyc(20);
    rd(8'h30, "R7 count held");
    wr(8'h20, 32'd7);
    wait_cyc(20);
    rd(8'h30, "R7 resumed");

    // R9 enable gating
    wr(8'h34, 32'd0);
    wait_cyc(10);
    check(irq === 1'b0, "R9 masked", {31'd0, irq}, 32'd0);
    wr(8'h34, 32'd1);

    // R8 expiry versus clear in same cycle
    wr(8'h00, 32'd0);
    wr(8'h08, 32'h8000_0002);
    @(negedge clk);
    bus_wr = 1; bus_addr = 8'h30; bus_wdata = 32'd1;
    repeat (20) @(negedge clk);
    bus_wr = 0;
    rd(8'h30, "R8 set wins");
    wait_cyc(5);
    rd(8'h40, "R10 final");
    rd(8'h20, "R11 ctrl");

    done = 1;
    summary();
    $finish;
  end
endmodule